// File: doc/BRIEF.md
# Exception State Save and Restore Unit

This unit manages the processor-state bookkeeping that surrounds an exception in a core that runs either a 32-bit wide instruction set or a 16-bit compressed one. When an exception is taken, the unit receives the exception code, the address of the relevant instruction and the current status word. It then computes the link address, stores it in the banked link register of the target mode, saves the incoming status word in that mode's saved-status register, and produces the new status word for the handler.

When a return is requested, the unit selects the bank from the mode field of the current status word. It produces the return address by subtracting an exception-specific offset from that bank's link register. It also hands back the saved status word, and restoring that word brings back the instruction-set state bit and the interrupt-disable flags as they were before the exception.

A branch-with-link uses the same path but touches only the link register of the current mode. Both strobes are single-cycle, and every result appears one cycle after its strobe.

Top module: `exc_state_unit`

## Requirements
- R1: While reset is asserted and after it is released, `ret_valid_o` and `status_valid_o` are 0, and `ret_pc_o` and `status_o` are 0.
- R2: The exception codes are RESET=0, UNDEF=1, SWI=2, PABT=3, DABT=4, IRQ=5, FIQ=6 and BL=7. For BL, SWI and UNDEF, the link value is PC+4 when status bit 5 (state bit) is 0, and PC+2 when it is 1.
- R3: For IRQ, FIQ and PABT the link value is PC+4, and for DABT it is PC+8, whatever the value of the state bit.
- R4: A return strobe yields `ret_valid_o`=1 in the next cycle only. `ret_pc_o` is the link register of the current bank minus 0 for BL, SWI and UNDEF, minus 4 for IRQ, FIQ and PABT, and minus 8 for DABT.
- R5: One cycle after an entry other than BL, `status_valid_o`=1 for one cycle. `status_o` then equals the input status with bits [4:0] set to the target mode, bit 5 cleared, bit 7 (IRQ-disable) set, and bit 6 (FIQ-disable) set only for FIQ and RESET. All other bits are unchanged.
- R6: A return other than BL, made from a mode that has a saved-status bank, sets `status_o` to that bank's saved word. This restores the state bit and both disable flags.
- R7: The mode codes are user 0x10, FIQ 0x11, IRQ 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F. SWI and RESET use the supervisor bank, UNDEF uses the undefined bank, PABT and DABT share the abort bank, and IRQ and FIQ each have their own bank. The banks are independent, so nested entries restore correctly.
- R8: BL writes only the link register of the bank selected by the current mode. It changes neither the saved status nor the mode, and neither its entry nor its return raises `status_valid_o`.
- R9: A return strobe carrying the RESET code has no effect: neither valid output rises. A RESET entry writes an implementation-chosen link value.
- R10: When entry and return strobes arrive in the same cycle, the entry is performed and the return is ignored.
- R11: A return made from user or system mode produces a return address but no status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enter_i | input | 1 | One-cycle exception entry strobe |
| ret_i | input | 1 | One-cycle exception return strobe |
| exc_code_i | input | 3 | Exception code for entry or return |
| pc_i | input | PC_W | Address of the instruction tied to the exception |
| status_i | input | ST_W | Current status word |
| ret_pc_o | output | PC_W | Return address |
| ret_valid_o | output | 1 | Return address valid |
| status_o | output | ST_W | New status word (entry) or restored word (return) |
| status_valid_o | output | 1 | Status word valid |

## Verification
Each entry or return result is registered and becomes visible exactly one clock after the rising edge that captured its strobe. The bench drives each strobe on a falling edge and holds it for a single cycle. It then reads the outputs on the very next falling edge, which lies after the capturing edge and before any later one. Because the link registers are not directly visible, link values are judged through the return address that a later return produces. Status checks are made only in cycles where the valid flag is expected to be 1; in other cycles only the valid flag itself is checked.

// File: rtl/exc_pkg.sv
package exc_pkg;

   typedef enum logic [2:0] {
      EXC_RESET = 3'd0,
      EXC_UNDEF = 3'd1,
      EXC_SWI   = 3'd2,
      EXC_PABT  = 3'd3,
      EXC_DABT  = 3'd4,
      EXC_IRQ   = 3'd5,
      EXC_FIQ   = 3'd6,
      EXC_BL    = 3'd7
   } exc_code_t;

   typedef enum logic [2:0] {
      BANK_USR = 3'd0,
      BANK_SVC = 3'd1,
      BANK_UND = 3'd2,
      BANK_ABT = 3'd3,
      BANK_IRQ = 3'd4,
      BANK_FIQ = 3'd5
   } bank_t;

   localparam int NUM_BANKS = 6;
   localparam int MODE_W    = 5;
   localparam int T_BIT     = 5;
   localparam int F_BIT     = 6;
   localparam int I_BIT     = 7;

   localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
   localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
   localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
   localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
   localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
   localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
   localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

   function automatic bank_t mode_to_bank(input logic [MODE_W-1:0] m);
      bank_t b;
      case (m)
         MODE_FIQ: b = BANK_FIQ;
         MODE_IRQ: b = BANK_IRQ;
         MODE_SVC: b = BANK_SVC;
         MODE_ABT: b = BANK_ABT;
         MODE_UND: b = BANK_UND;
         default:  b = BANK_USR;
      endcase
      return b;
   endfunction

   function automatic bank_t exc_to_bank(input exc_code_t c);
      bank_t b;
      case (c)
         EXC_RESET, EXC_SWI:  b = BANK_SVC;
         EXC_UNDEF:           b = BANK_UND;
         EXC_PABT, EXC_DABT:  b = BANK_ABT;
         EXC_IRQ:             b = BANK_IRQ;
         EXC_FIQ:             b = BANK_FIQ;
         default:             b = BANK_USR;
      endcase
      return b;
   endfunction

   function automatic logic [MODE_W-1:0] exc_to_mode(input exc_code_t c);
      logic [MODE_W-1:0] m;
      case (c)
         EXC_RESET, EXC_SWI:  m = MODE_SVC;
         EXC_UNDEF:           m = MODE_UND;
         EXC_PABT, EXC_DABT:  m = MODE_ABT;
         EXC_IRQ:             m = MODE_IRQ;
         EXC_FIQ:             m = MODE_FIQ;
         default:             m = MODE_USR;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/exc_offset_calc.sv
module exc_offset_calc
   import exc_pkg::*;
#(
   parameter int              PC_W       = 32,
   parameter logic [PC_W-1:0] RESET_LINK = '0
) (
   input  exc_code_t         code_i,
   input  logic              thumb_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [PC_W-1:0]   link_i,
   output logic [PC_W-1:0]   link_val_o,
   output logic [PC_W-1:0]   ret_val_o
);

   localparam logic [PC_W-1:0] OFF_0 = '0;
   localparam logic [PC_W-1:0] OFF_2 = PC_W'(2);
   localparam logic [PC_W-1:0] OFF_4 = PC_W'(4);
   localparam logic [PC_W-1:0] OFF_8 = PC_W'(8);

   logic [PC_W-1:0] link_off;
   logic [PC_W-1:0] ret_off;

   always_comb begin
      case (code_i)
         EXC_BL, EXC_SWI, EXC_UNDEF: link_off = thumb_i ? OFF_2 : OFF_4;
         EXC_PABT, EXC_IRQ, EXC_FIQ: link_off = OFF_4;
         EXC_DABT:                   link_off = OFF_8;
         default:                    link_off = OFF_0;
      endcase
   end

   always_comb begin
      case (code_i)
         EXC_PABT, EXC_IRQ, EXC_FIQ: ret_off = OFF_4;
         EXC_DABT:                   ret_off = OFF_8;
         default:                    ret_off = OFF_0;
      endcase
   end

   assign link_val_o = (code_i == EXC_RESET) ? RESET_LINK : pc_i + link_off;
   assign ret_val_o  = link_i - ret_off;

endmodule

// File: rtl/exc_entry_status.sv
module exc_entry_status
   import exc_pkg::*;
#(
   parameter int ST_W = 32
) (
   input  exc_code_t         code_i,
   input  logic [ST_W-1:0]   status_i,
   output logic [ST_W-1:0]   status_o
);

   logic mask_fiq;

   assign mask_fiq = (code_i == EXC_FIQ) || (code_i == EXC_RESET);

   always_comb begin
      status_o               = status_i;
      status_o[MODE_W-1:0]   = exc_to_mode(code_i);
      status_o[T_BIT]        = 1'b0;
      status_o[I_BIT]        = 1'b1;
      if (mask_fiq) begin
         status_o[F_BIT]     = 1'b1;
      end
   end

endmodule

// File: rtl/exc_bank_file.sv
module exc_bank_file
   import exc_pkg::*;
#(
   parameter int PC_W = 32,
   parameter int ST_W = 32,
   parameter int NB   = NUM_BANKS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lr_we_i,
   input  bank_t             lr_sel_i,
   input  logic [PC_W-1:0]   lr_wdata_i,
   input  logic              sr_we_i,
   input  bank_t             sr_sel_i,
   input  logic [ST_W-1:0]   sr_wdata_i,
   input  bank_t             rd_sel_i,
   output logic [PC_W-1:0]   lr_rdata_o,
   output logic [ST_W-1:0]   sr_rdata_o,
   output logic              sr_present_o
);

   logic [PC_W-1:0] lr_q [NB];
   logic [ST_W-1:0] sr_q [NB];
   logic [NB-1:0]   has_sr;

   for (genvar g = 0; g < NB; g++) begin : g_bank
      logic [PC_W-1:0] lr_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lr_r <= '0;
         end else if (lr_we_i && (int'(lr_sel_i) == g)) begin
            lr_r <= lr_wdata_i;
         end
      end
      assign lr_q[g] = lr_r;

      if (g == int'(BANK_USR)) begin : g_no_sr
         assign sr_q[g]   = '0;
         assign has_sr[g] = 1'b0;
      end else begin : g_sr
         logic [ST_W-1:0] sr_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr_r <= '0;
            end else if (sr_we_i && (int'(sr_sel_i) == g)) begin
               sr_r <= sr_wdata_i;
            end
         end
         assign sr_q[g]   = sr_r;
         assign has_sr[g] = 1'b1;
      end
   end

   assign lr_rdata_o   = lr_q[rd_sel_i];
   assign sr_rdata_o   = sr_q[rd_sel_i];
   assign sr_present_o = has_sr[rd_sel_i];

endmodule

// File: rtl/exc_state_unit.sv
module exc_state_unit
   import exc_pkg::*;
#(
   parameter int              PC_W       = 32,
   parameter int              ST_W       = 32,
   parameter logic [PC_W-1:0] RESET_LINK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enter_i,
   input  logic              ret_i,
   input  logic [2:0]        exc_code_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [ST_W-1:0]   status_i,
   output logic [PC_W-1:0]   ret_pc_o,
   output logic              ret_valid_o,
   output logic [ST_W-1:0]   status_o,
   output logic              status_valid_o
);

   if (ST_W < 8) begin : g_chk_st
      $error("status word must hold mode, state and both disable flags");
   end
   if (PC_W < 4) begin : g_chk_pc
      $error("address width too small for the link offsets");
   end

   exc_code_t       code;
   bank_t           cur_bank;
   bank_t           tgt_bank;
   logic            is_bl;
   logic            do_enter;
   logic            do_ret;
   logic [PC_W-1:0] link_val;
   logic [PC_W-1:0] ret_val;
   logic [PC_W-1:0] lr_rdata;
   logic [ST_W-1:0] sr_rdata;
   logic            sr_present;
   logic [ST_W-1:0] entry_status;

   assign code     = exc_code_t'(exc_code_i);
   assign cur_bank = mode_to_bank(status_i[MODE_W-1:0]);
   assign tgt_bank = exc_to_bank(code);
   assign is_bl    = (code == EXC_BL);
   assign do_enter = enter_i;
   assign do_ret   = ret_i && !enter_i && (code != EXC_RESET);

   exc_offset_calc #(
      .PC_W       (PC_W),
      .RESET_LINK (RESET_LINK)
   ) u_offs (
      .code_i     (code),
      .thumb_i    (status_i[T_BIT]),
      .pc_i       (pc_i),
      .link_i     (lr_rdata),
      .link_val_o (link_val),
      .ret_val_o  (ret_val)
   );

   exc_entry_status #(
      .ST_W (ST_W)
   ) u_entry (
      .code_i   (code),
      .status_i (status_i),
      .status_o (entry_status)
   );

   exc_bank_file #(
      .PC_W (PC_W),
      .ST_W (ST_W),
      .NB   (NUM_BANKS)
   ) u_banks (
      .clk          (clk),
      .rst_n        (rst_n),
      .lr_we_i      (do_enter),
      .lr_sel_i     (is_bl ? cur_bank : tgt_bank),
      .lr_wdata_i   (link_val),
      .sr_we_i      (do_enter && !is_bl),
      .sr_sel_i     (tgt_bank),
      .sr_wdata_i   (status_i),
      .rd_sel_i     (cur_bank),
      .lr_rdata_o   (lr_rdata),
      .sr_rdata_o   (sr_rdata),
      .sr_present_o (sr_present)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_o       <= '0;
         status_valid_o <= 1'b0;
      end else if (do_enter && !is_bl) begin
         status_o       <= entry_status;
         status_valid_o <= 1'b1;
      end else if (do_ret && !is_bl && sr_present) begin
         status_o       <= sr_rdata;
         status_valid_o <= 1'b1;
      end else begin
         status_valid_o <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ret_pc_o    <= '0;
         ret_valid_o <= 1'b0;
      end else begin
         ret_valid_o <= do_ret;
         if (do_ret) begin
            ret_pc_o <= ret_val;
         end
      end
   end

endmodule

// File: rtl/exc_state_unit_chk.sv
module exc_state_unit_chk
   import exc_pkg::*;
#(
   parameter int ST_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            enter_i,
   input logic            ret_i,
   input logic [2:0]      exc_code_i,
   input logic [ST_W-1:0] status_o,
   input logic            status_valid_o,
   input logic            ret_valid_o
);

   a_r5_status_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (enter_i && exc_code_i != 3'd7) |=> (status_valid_o && !status_o[T_BIT] && status_o[I_BIT]));

   a_r7_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (enter_i && exc_code_i == 3'd5) |=> (status_o[MODE_W-1:0] == MODE_IRQ));

   a_r4_ret_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !enter_i && exc_code_i != 3'd0) |=> ret_valid_o);

   a_r4_ret_single: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid_o |-> $past(ret_i && !enter_i));

   a_r8_bl_no_status: assert property (@(posedge clk) disable iff (!rst_n)
      ((enter_i || ret_i) && exc_code_i == 3'd7) |=> !status_valid_o);

   a_r9_reset_no_return: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !enter_i && exc_code_i == 3'd0) |=> (!ret_valid_o && !status_valid_o));

   a_r10_entry_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (enter_i && ret_i) |=> !ret_valid_o);

endmodule

bind exc_state_unit exc_state_unit_chk #(.ST_W(ST_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .enter_i        (enter_i),
   .ret_i          (ret_i),
   .exc_code_i     (exc_code_i),
   .status_o       (status_o),
   .status_valid_o (status_valid_o),
   .ret_valid_o    (ret_valid_o)
);

// File: tb/tb_exc_state_unit.sv
module tb_exc_state_unit;

   localparam int CLK_PERIOD = 10;
   localparam int NROWS      = 13;
   localparam int WDOG       = 20000;

   localparam logic [2:0] C_RESET = 3'd0, C_UNDEF = 3'd1, C_SWI = 3'd2, C_PABT = 3'd3,
                          C_DABT = 3'd4, C_IRQ = 3'd5, C_FIQ = 3'd6, C_BL = 3'd7;

   // row: {code, state bit, pc, expected return address}
   localparam logic [67:0] VEC [NROWS] = '{
      {C_SWI,   1'b0, 32'h0000_0100, 32'h0000_0104},
      {C_SWI,   1'b1, 32'h0000_0200, 32'h0000_0202},
      {C_UNDEF, 1'b0, 32'h0000_0300, 32'h0000_0304},
      {C_UNDEF, 1'b1, 32'h0000_0310, 32'h0000_0312},
      {C_PABT,  1'b0, 32'h0000_0400, 32'h0000_0400},
      {C_PABT,  1'b1, 32'h0000_0410, 32'h0000_0410},
      {C_DABT,  1'b0, 32'h0000_0500, 32'h0000_0500},
      {C_DABT,  1'b1, 32'h0000_0510, 32'h0000_0510},
      {C_IRQ,   1'b1, 32'h0000_0600, 32'h0000_0600},
      {C_IRQ,   1'b0, 32'h0000_0604, 32'h0000_0604},
      {C_FIQ,   1'b1, 32'h0000_0700, 32'h0000_0700},
      {C_BL,    1'b0, 32'h0000_0800, 32'h0000_0804},
      {C_BL,    1'b1, 32'h0000_0900, 32'h0000_0902}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enter_i = 1'b0;
   logic        ret_i = 1'b0;
   logic [2:0]  exc_code_i = '0;
   logic [31:0] pc_i = '0;
   logic [31:0] status_i = '0;
   logic [31:0] ret_pc_o;
   logic        ret_valid_o;
   logic [31:0] status_o;
   logic        status_valid_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_state_unit dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .enter_i        (enter_i),
      .ret_i          (ret_i),
      .exc_code_i     (exc_code_i),
      .pc_i           (pc_i),
      .status_i       (status_i),
      .ret_pc_o       (ret_pc_o),
      .ret_valid_o    (ret_valid_o),
      .status_o       (status_o),
      .status_valid_o (status_valid_o)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_entry(input logic [2:0] c, input logic [31:0] s);
      logic [31:0] r = s;
      case (c)
         C_RESET, C_SWI: r[4:0] = 5'h13;
         C_UNDEF:        r[4:0] = 5'h1B;
         C_PABT, C_DABT: r[4:0] = 5'h17;
         C_IRQ:          r[4:0] = 5'h12;
         C_FIQ:          r[4:0] = 5'h11;
         default:        r[4:0] = s[4:0];
      endcase
      r[5] = 1'b0;
      r[7] = 1'b1;
      if (c == C_FIQ || c == C_RESET) r[6] = 1'b1;
      return r;
   endfunction

   task automatic strobe(input bit en, input bit rt, input logic [2:0] c,
                         input logic [31:0] pc, input logic [31:0] st);
      @(negedge clk);
      enter_i    = en;
      ret_i      = rt;
      exc_code_i = c;
      pc_i       = pc;
      status_i   = st;
      @(negedge clk);
      enter_i    = 1'b0;
      ret_i      = 1'b0;
   endtask

   initial begin
      int cyc = 0;
      while (!done && cyc < WDOG) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WDOG);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] s0, s1, s2, e;
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1", "ret_valid in reset", {31'b0, ret_valid_o}, 32'd0);
      check("R1", "status_valid in reset", {31'b0, status_valid_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "ret_pc after reset", ret_pc_o, 32'd0);
      check("R1", "status after reset", status_o, 32'd0);
      check("R1", "valids after reset", {30'b0, ret_valid_o, status_valid_o}, 32'd0);

      // table walk: entry from user mode, then return from the target mode
      for (int i = 0; i < NROWS; i++) begin
         logic [2:0]  c  = VEC[i][67:65];
         logic        t  = VEC[i][64];
         logic [31:0] pc = VEC[i][63:32];
         logic [31:0] er = VEC[i][31:0];
         string       rq = (c == C_BL || c == C_SWI || c == C_UNDEF) ? "R2" : "R3";
         s0 = 32'hC000_0010 | (32'(t) << 5);
         strobe(1'b1, 1'b0, c, pc, s0);
         if (c == C_BL) begin
            check("R8", "BL entry status_valid", {31'b0, status_valid_o}, 32'd0);
            strobe(1'b0, 1'b1, c, 32'h0, s0);
            check(rq, "BL return address", ret_pc_o, er);
            check("R8", "BL return status_valid", {31'b0, status_valid_o}, 32'd0);
         end else begin
            e = exp_entry(c, s0);
            check("R5", "entry status_valid", {31'b0, status_valid_o}, 32'd1);
            check("R5", "entry status", status_o, e);
            strobe(1'b0, 1'b1, c, 32'h0, e);
            check("R4", "ret_valid", {31'b0, ret_valid_o}, 32'd1);
            check(rq, "return address", ret_pc_o, er);
            check("R6", "restored status", status_o, s0);
         end
         @(negedge clk);
         check("R4", "ret_valid one cycle", {31'b0, ret_valid_o}, 32'd0);
      end

      // R7: nested IRQ then SWI, banks independent
      s0 = 32'h0000_0030;
      strobe(1'b1, 1'b0, C_IRQ, 32'h1000, s0);
      s1 = exp_entry(C_IRQ, s0);
      check("R7", "IRQ entry status", status_o, s1);
      strobe(1'b1, 1'b0, C_SWI, 32'h2000, s1);
      s2 = exp_entry(C_SWI, s1);
      check("R7", "nested SWI entry status", status_o, s2);
      strobe(1'b0, 1'b1, C_SWI, 32'h0, s2);
      check("R7", "SWI return address", ret_pc_o, 32'h2004);
      check("R7", "SWI restores IRQ status", status_o, s1);
      strobe(1'b0, 1'b1, C_IRQ, 32'h0, s1);
      check("R7", "IRQ return address", ret_pc_o, 32'h1000);
      check("R6", "state bit and flags restored", status_o, s0);

      // R8: BL in supervisor mode overwrites only the supervisor link
      s0 = 32'h0000_0010;
      strobe(1'b1, 1'b0, C_SWI, 32'h4000, s0);
      s1 = exp_entry(C_SWI, s0);
      strobe(1'b1, 1'b0, C_BL, 32'h5000, s1);
      check("R8", "BL entry no status", {31'b0, status_valid_o}, 32'd0);
      strobe(1'b0, 1'b1, C_SWI, 32'h0, s1);
      check("R8", "link replaced by BL", ret_pc_o, 32'h5004);
      check("R8", "saved status kept", status_o, s0);

      // R9: reset entry and an ignored reset return
      s0 = 32'h0000_0030;
      strobe(1'b1, 1'b0, C_RESET, 32'h6000, s0);
      check("R9", "reset entry status", status_o, exp_entry(C_RESET, s0));
      strobe(1'b0, 1'b1, C_RESET, 32'h0, 32'h0000_00D3);
      check("R9", "reset return valids", {30'b0, ret_valid_o, status_valid_o}, 32'd0);

      // R10: simultaneous entry and return
      s0 = 32'h0000_0010;
      strobe(1'b1, 1'b1, C_UNDEF, 32'h3000, s0);
      check("R10", "return ignored", {31'b0, ret_valid_o}, 32'd0);
      check("R10", "entry performed", status_o, exp_entry(C_UNDEF, s0));
      strobe(1'b0, 1'b1, C_UNDEF, 32'h0, exp_entry(C_UNDEF, s0));
      check("R10", "entry link stored", ret_pc_o, 32'h3004);

      // R11: return from system mode
      strobe(1'b0, 1'b1, C_SWI, 32'h0, 32'h0000_001F);
      check("R11", "valids from system mode", {30'b0, ret_valid_o, status_valid_o}, 32'd2);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule